// File: doc/BRIEF.md
# Up/Down Counter Bank with Read-Modify-Write Forwarding

This block holds a bank of 16-bit event counters in a storage array whose reads and writes each take two clock cycles. On any clock a caller may present a valid command naming one counter and asking for it to count up or down by one. The block fetches the counter, adjusts it, stores the result back, and reports the new value together with the counter's address a fixed three cycles after the command.

A command can arrive on every cycle, and several commands in a row can name the same counter. A new command may therefore read a counter whose latest value has not yet reached storage. Results that are still on their way to storage are held in a short chain of registers. Each new command compares its address against that chain and takes the newest matching value in place of the stale stored one. No command is ever stalled or dropped.

Top module: `rmw_counter_bank`

## Requirements
- R1: After reset every counter holds zero and `res_valid` is low until the first result is due.
- R2: A command accepted with `cmd_valid` high at a clock edge produces exactly one result, with `res_valid` high and `res_addr` equal to the command's address, in the cycle that follows the third rising edge counted from that acceptance edge.
- R3: `cmd_inc` = 1 adds one to the addressed counter and `cmd_inc` = 0 subtracts one; the result carries the adjusted value.
- R4: Counters wrap modulo 2^16: decrementing 0x0000 gives 0xFFFF and incrementing 0xFFFF gives 0x0000.
- R5: Commands to the same counter at distances of one, two, three or more cycles each see the result of every earlier command, so a run of N commands changes the counter by exactly the net count of its opcodes.
- R6: Commands to different counters, in any interleaving, leave each other's values unaffected.
- R7: A cycle with `cmd_valid` low yields no result and changes no counter, whatever `cmd_addr` and `cmd_inc` carry.
- R8: Every result is written to storage with the same address and value, one cycle after it appears on the result port, and is read back correctly by later commands after forwarding no longer covers it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_addr | input | ADDR_W | Counter selected by the command |
| cmd_inc | input | 1 | 1 = count up, 0 = count down |
| res_valid | output | 1 | Result present this cycle |
| res_addr | output | ADDR_W | Counter the result belongs to |
| res_count | output | CNT_W | Counter value after the command |

## Verification
On every cycle the assertions check the result timing and address against a shadow of the command stream. They check that consecutive results for one counter differ by exactly the opcode of the later command, which is the forwarding hazard at distance one. They also check that each storage write repeats the earlier result's address and value one cycle later. Hazards at distances two and three, wrap-around, and the read-back of values committed long before are only visible through the bench's scenarios. Those compare every cycle against a behavioural model that applies commands in order, as are the absence of any effect from idle cycles and the independence of interleaved counters.

// File: rtl/rmw_cnt_pkg.sv
package rmw_cnt_pkg;

  // Opcode carried on cmd_inc.
  typedef enum logic {
    OP_DOWN = 1'b0,
    OP_UP   = 1'b1
  } cnt_op_e;

  localparam int DEF_ADDR_W = 6;
  localparam int DEF_CNT_W  = 16;
  localparam int DEF_RD_LAT = 2;
  localparam int DEF_WR_LAT = 2;

endpackage

// File: rtl/rmw_cmd_pipe.sv
// Delays the command fields so that they line up with the storage read data.
module rmw_cmd_pipe #(
  parameter int ADDR_W = 6,
  parameter int STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic              in_inc,
  output logic              out_valid,
  output logic [ADDR_W-1:0] out_addr,
  output logic              out_inc
);

  logic              p_valid [STAGES];
  logic [ADDR_W-1:0] p_addr  [STAGES];
  logic              p_inc   [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) begin
            p_valid[0] <= 1'b0;
            p_addr[0]  <= '0;
            p_inc[0]   <= 1'b0;
          end else begin
            p_valid[0] <= in_valid;
            p_addr[0]  <= in_addr;
            p_inc[0]   <= in_inc;
          end
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) begin
            p_valid[s] <= 1'b0;
            p_addr[s]  <= '0;
            p_inc[s]   <= 1'b0;
          end else begin
            p_valid[s] <= p_valid[s-1];
            p_addr[s]  <= p_addr[s-1];
            p_inc[s]   <= p_inc[s-1];
          end
        end
      end
    end
  endgenerate

  assign out_valid = p_valid[STAGES-1];
  assign out_addr  = p_addr[STAGES-1];
  assign out_inc   = p_inc[STAGES-1];

endmodule

// File: rtl/rmw_mem_model.sv
// Counter storage: a read returns data RD_LAT edges after its address is
// presented; a write request is applied to the array at the next edge.
module rmw_mem_model #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16,
  parameter int RD_LAT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data
);

  localparam int WORDS    = 1 << ADDR_W;
  localparam int ADDR_STG = RD_LAT - 1;

  logic [DATA_W-1:0] store [WORDS];
  logic [ADDR_W-1:0] a_pipe [ADDR_STG];

  genvar s;
  generate
    for (s = 0; s < ADDR_STG; s++) begin : g_addr
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) a_pipe[0] <= '0;
          else        a_pipe[0] <= rd_addr;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) a_pipe[s] <= '0;
          else        a_pipe[s] <= a_pipe[s-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) rd_data <= '0;
    else        rd_data <= store[a_pipe[ADDR_STG-1]];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int w = 0; w < WORDS; w++) store[w] <= '0;
    end else if (wr_en) begin
      store[wr_addr] <= wr_data;
    end
  end

endmodule

// File: rtl/rmw_fwd_chain.sv
// Chain of results not yet visible to storage reads. Entry 0 is the newest.
// Entry DEPTH-2 is the one being committed; entry DEPTH-1 was committed
// one edge ago and is still hidden from a read already under way.
module rmw_fwd_chain #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16,
  parameter int DEPTH  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_valid,
  input  logic [ADDR_W-1:0] push_addr,
  input  logic [DATA_W-1:0] push_data,
  input  logic [ADDR_W-1:0] look_addr,
  output logic              hit,
  output logic [DATA_W-1:0] hit_data,
  output logic              head_valid,
  output logic [ADDR_W-1:0] head_addr,
  output logic [DATA_W-1:0] head_data,
  output logic              commit_valid,
  output logic [ADDR_W-1:0] commit_addr,
  output logic [DATA_W-1:0] commit_data
);

  logic              e_valid [DEPTH];
  logic [ADDR_W-1:0] e_addr  [DEPTH];
  logic [DATA_W-1:0] e_data  [DEPTH];

  genvar k;
  generate
    for (k = 0; k < DEPTH; k++) begin : g_ent
      if (k == 0) begin : g_head
        always_ff @(posedge clk) begin
          if (!rst_n) begin
            e_valid[0] <= 1'b0;
            e_addr[0]  <= '0;
            e_data[0]  <= '0;
          end else begin
            e_valid[0] <= push_valid;
            e_addr[0]  <= push_addr;
            e_data[0]  <= push_data;
          end
        end
      end else begin : g_tail
        always_ff @(posedge clk) begin
          if (!rst_n) begin
            e_valid[k] <= 1'b0;
            e_addr[k]  <= '0;
            e_data[k]  <= '0;
          end else begin
            e_valid[k] <= e_valid[k-1];
            e_addr[k]  <= e_addr[k-1];
            e_data[k]  <= e_data[k-1];
          end
        end
      end
    end
  endgenerate

  // Oldest first so that the newest match is the one left standing.
  always_comb begin
    hit      = 1'b0;
    hit_data = '0;
    for (int j = DEPTH - 1; j >= 0; j--) begin
      if (e_valid[j] && (e_addr[j] == look_addr)) begin
        hit      = 1'b1;
        hit_data = e_data[j];
      end
    end
  end

  assign head_valid   = e_valid[0];
  assign head_addr    = e_addr[0];
  assign head_data    = e_data[0];
  assign commit_valid = e_valid[DEPTH-2];
  assign commit_addr  = e_addr[DEPTH-2];
  assign commit_data  = e_data[DEPTH-2];

endmodule

// File: rtl/rmw_counter_bank.sv
// Bank of up/down counters with read-modify-write and result forwarding.
// RD_LAT and WR_LAT must each be at least 2.
module rmw_counter_bank #(
  parameter int ADDR_W = rmw_cnt_pkg::DEF_ADDR_W,
  parameter int CNT_W  = rmw_cnt_pkg::DEF_CNT_W,
  parameter int RD_LAT = rmw_cnt_pkg::DEF_RD_LAT,
  parameter int WR_LAT = rmw_cnt_pkg::DEF_WR_LAT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic              cmd_inc,
  output logic              res_valid,
  output logic [ADDR_W-1:0] res_addr,
  output logic [CNT_W-1:0]  res_count
);

  // Every result newer than the last one a read can see must be searchable.
  localparam int FWD_N = WR_LAT + 1;

  function automatic logic [CNT_W-1:0] step_count(input logic [CNT_W-1:0] cur,
                                                  input logic             up);
    if (rmw_cnt_pkg::cnt_op_e'(up) == rmw_cnt_pkg::OP_UP) return cur + CNT_W'(1);
    else                                                  return cur - CNT_W'(1);
  endfunction

  // Named internal events, also used by the bound checker.
  logic              exe_valid;
  logic [ADDR_W-1:0] exe_addr;
  logic              exe_inc;
  logic [CNT_W-1:0]  mem_rd_data;
  logic              fwd_hit;
  logic [CNT_W-1:0]  fwd_data;
  logic [CNT_W-1:0]  base_count;
  logic [CNT_W-1:0]  next_count;
  logic              mem_wr_en;
  logic [ADDR_W-1:0] mem_wr_addr;
  logic [CNT_W-1:0]  mem_wr_data;

  rmw_cmd_pipe #(
    .ADDR_W (ADDR_W),
    .STAGES (RD_LAT)
  ) u_cmd_pipe (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (cmd_valid),
    .in_addr   (cmd_addr),
    .in_inc    (cmd_inc),
    .out_valid (exe_valid),
    .out_addr  (exe_addr),
    .out_inc   (exe_inc)
  );

  rmw_mem_model #(
    .ADDR_W (ADDR_W),
    .DATA_W (CNT_W),
    .RD_LAT (RD_LAT)
  ) u_mem (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_addr (cmd_addr),
    .rd_data (mem_rd_data),
    .wr_en   (mem_wr_en),
    .wr_addr (mem_wr_addr),
    .wr_data (mem_wr_data)
  );

  rmw_fwd_chain #(
    .ADDR_W (ADDR_W),
    .DATA_W (CNT_W),
    .DEPTH  (FWD_N)
  ) u_fwd (
    .clk          (clk),
    .rst_n        (rst_n),
    .push_valid   (exe_valid),
    .push_addr    (exe_addr),
    .push_data    (next_count),
    .look_addr    (exe_addr),
    .hit          (fwd_hit),
    .hit_data     (fwd_data),
    .head_valid   (res_valid),
    .head_addr    (res_addr),
    .head_data    (res_count),
    .commit_valid (mem_wr_en),
    .commit_addr  (mem_wr_addr),
    .commit_data  (mem_wr_data)
  );

  assign base_count = fwd_hit ? fwd_data : mem_rd_data;
  assign next_count = step_count(base_count, exe_inc);

endmodule

// File: rtl/rmw_counter_bank_chk.sv
module rmw_counter_bank_chk #(
  parameter int ADDR_W = 6,
  parameter int CNT_W  = 16,
  parameter int RD_LAT = 2,
  parameter int WR_LAT = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic [ADDR_W-1:0] cmd_addr,
  input logic              cmd_inc,
  input logic              res_valid,
  input logic [ADDR_W-1:0] res_addr,
  input logic [CNT_W-1:0]  res_count,
  input logic              mem_wr_en,
  input logic [ADDR_W-1:0] mem_wr_addr,
  input logic [CNT_W-1:0]  mem_wr_data
);

  localparam int LAT  = RD_LAT + 1;
  localparam int HIST = WR_LAT - 1;

  logic              sh_v [LAT];
  logic [ADDR_W-1:0] sh_a [LAT];
  logic              sh_i [LAT];
  logic              rh_v [HIST];
  logic [ADDR_W-1:0] rh_a [HIST];
  logic [CNT_W-1:0]  rh_c [HIST];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < LAT; k++) begin
        sh_v[k] <= 1'b0; sh_a[k] <= '0; sh_i[k] <= 1'b0;
      end
      for (int k = 0; k < HIST; k++) begin
        rh_v[k] <= 1'b0; rh_a[k] <= '0; rh_c[k] <= '0;
      end
    end else begin
      sh_v[0] <= cmd_valid; sh_a[0] <= cmd_addr; sh_i[0] <= cmd_inc;
      for (int k = 1; k < LAT; k++) begin
        sh_v[k] <= sh_v[k-1]; sh_a[k] <= sh_a[k-1]; sh_i[k] <= sh_i[k-1];
      end
      rh_v[0] <= res_valid; rh_a[0] <= res_addr; rh_c[0] <= res_count;
      for (int k = 1; k < HIST; k++) begin
        rh_v[k] <= rh_v[k-1]; rh_a[k] <= rh_a[k-1]; rh_c[k] <= rh_c[k-1];
      end
    end
  end

  AST_RESULT_TIMING: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid == sh_v[LAT-1]); // R2

  AST_RESULT_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_addr == sh_a[LAT-1])); // R2

  AST_BACK_TO_BACK_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && $past(res_valid) && (res_addr == $past(res_addr))) |->
      (res_count == (sh_i[LAT-1] ? CNT_W'($past(res_count) + CNT_W'(1))
                                 : CNT_W'($past(res_count) - CNT_W'(1))))); // R5

  AST_COMMIT_TIMING: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en == rh_v[HIST-1]); // R8

  AST_COMMIT_PAYLOAD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |-> ((mem_wr_addr == rh_a[HIST-1]) && (mem_wr_data == rh_c[HIST-1]))); // R8

endmodule

bind rmw_counter_bank rmw_counter_bank_chk #(
  .ADDR_W (ADDR_W),
  .CNT_W  (CNT_W),
  .RD_LAT (RD_LAT),
  .WR_LAT (WR_LAT)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cmd_valid   (cmd_valid),
  .cmd_addr    (cmd_addr),
  .cmd_inc     (cmd_inc),
  .res_valid   (res_valid),
  .res_addr    (res_addr),
  .res_count   (res_count),
  .mem_wr_en   (mem_wr_en),
  .mem_wr_addr (mem_wr_addr),
  .mem_wr_data (mem_wr_data)
);

// File: tb/rmw_counter_bank_tb.sv
module rmw_counter_bank_tb_top;

  localparam int AW    = 6;
  localparam int CW    = 16;
  localparam int LAT   = 3;         // result latency from R2
  localparam int NCNT  = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic [AW-1:0] cmd_addr = '0;
  logic          cmd_inc = 1'b0;
  logic          res_valid;
  logic [AW-1:0] res_addr;
  logic [CW-1:0] res_count;

  always #2.5 clk = ~clk;   // 200 MHz

  rmw_counter_bank dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_addr  (cmd_addr),
    .cmd_inc   (cmd_inc),
    .res_valid (res_valid),
    .res_addr  (res_addr),
    .res_count (res_count)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Behavioural model: counters updated in command order.
  int    model [NCNT];
  bit    ex_v [LAT+1];
  int    ex_a [LAT+1];
  int    ex_c [LAT+1];
  string ex_r [LAT+1];

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d (0x%0h) expected %0d (0x%0h) at %0t",
               req, what, act, act, exp, exp, $time);
    end
  endtask

  // One cycle: compare outputs with the entry due now, then present a command.
  task automatic cycle(input bit v, input int a, input bit up, input string req);
    @(negedge clk);
    for (int k = LAT; k > 0; k--) begin
      ex_v[k] = ex_v[k-1]; ex_a[k] = ex_a[k-1]; ex_c[k] = ex_c[k-1]; ex_r[k] = ex_r[k-1];
    end
    ex_v[0] = v; ex_a[0] = a; ex_r[0] = req; ex_c[0] = 0;
    if (v) begin
      model[a] = up ? (model[a] + 1) % 65536 : (model[a] + 65535) % 65536;
      ex_c[0] = model[a];
    end
    check({ex_r[LAT], "/R2"}, "res_valid", int'(res_valid), int'(ex_v[LAT]));
    if (ex_v[LAT]) begin
      check({ex_r[LAT], "/R2"}, "res_addr", int'(res_addr), ex_a[LAT]);
      check(ex_r[LAT], "res_count", int'(res_count), ex_c[LAT]);
    end
    cmd_valid = v;
    cmd_addr  = AW'(a);
    cmd_inc   = up;
  endtask

  task automatic drain();
    for (int k = 0; k < LAT + 2; k++) cycle(1'b0, 0, 1'b0, "R7");
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    for (int i = 0; i < NCNT; i++) model[i] = 0;
    for (int k = 0; k <= LAT; k++) begin
      ex_v[k] = 1'b0; ex_a[k] = 0; ex_c[k] = 0; ex_r[k] = "R1";
    end
    repeat (4) @(negedge clk);
    check("R1", "res_valid in reset", int'(res_valid), 0);
    rst_n = 1'b1;
    // R1: idle after reset keeps res_valid low
    for (int k = 0; k < 3; k++) cycle(1'b0, 0, 1'b0, "R1");

    // R1/R3: first increment from reset value gives 1
    cycle(1'b1, 5, 1'b1, "R1");
    drain();
    cycle(1'b1, 5, 1'b1, "R3");
    cycle(1'b1, 6, 1'b1, "R3");
    drain();
    cycle(1'b1, 5, 1'b0, "R3");
    drain();

    // R4: wrap down from zero, then back up through 0xFFFF
    cycle(1'b1, 9, 1'b0, "R4");
    drain();
    cycle(1'b1, 9, 1'b1, "R4");
    cycle(1'b1, 9, 1'b0, "R4");
    cycle(1'b1, 9, 1'b0, "R4");
    cycle(1'b1, 9, 1'b1, "R4");
    drain();

    // R5: same counter on consecutive cycles
    for (int k = 0; k < 10; k++) cycle(1'b1, 12, 1'b1, "R5");
    for (int k = 0; k < 4; k++)  cycle(1'b1, 12, 1'b0, "R5");
    // R5: same counter at distance two and three
    for (int k = 0; k < 6; k++) begin
      cycle(1'b1, 20, 1'b1, "R5");
      cycle(1'b1, 21, (k % 2) == 0, "R5");
    end
    for (int k = 0; k < 6; k++) begin
      cycle(1'b1, 30, 1'b1, "R5");
      cycle(1'b1, 31, 1'b1, "R5");
      cycle(1'b1, 32, 1'b0, "R5");
    end
    drain();

    // R7: idle cycles with junk fields leave counters alone
    for (int k = 0; k < 8; k++) cycle(1'b0, 12 + (k % 2) * 8, k[0], "R7");
    drain();
    // R7/R8: reread long after commit; stored values unchanged by idles
    cycle(1'b1, 12, 1'b1, "R7");
    cycle(1'b1, 20, 1'b1, "R7");
    drain();
    cycle(1'b1, 30, 1'b1, "R8");
    drain();
    cycle(1'b1, 31, 1'b0, "R8");
    cycle(1'b1, 9, 1'b1, "R8");
    drain();

    // R6: random interleaving over a small set of counters
    for (int k = 0; k < 600; k++) begin
      automatic int r = int'($urandom_range(0, 99));
      cycle(r < 80, 40 + int'($urandom_range(0, 5)), $urandom_range(0, 2) != 0, "R6");
    end
    drain();
    // R8: read every random-test counter back from storage
    for (int a = 40; a < 46; a++) begin
      cycle(1'b1, a, 1'b0, "R8");
      drain();
    end

    done = 1'b1;
    finish_run();
  end

endmodule